// File: doc/BRIEF.md
# Two-Stage Wishbone Splitter with 64-to-32 IO Narrowing

This block sits between a 64-bit Wishbone master and the memory and peripheral slaves of a chip. A first decoder, working on the top address nibble, sends each request to one of three legs. Two of them are block RAM and DRAM. Both see the 64-bit bus with no added delay. The third is the IO leg, which takes every other address.

On the IO leg the request is captured into registers and then narrowed to 32 bits. A 64-bit access whose byte enables cover both 32-bit lanes becomes two 32-bit cycles in a row. An access that touches only one lane becomes a single cycle on that lane. A second decoder, working from the registered address, picks one of the 32-bit peripheral slots. A separate window is cut out of the IO space and sent to its own external port. If an IO address matches nothing, the bridge answers by itself with all-ones data, so the master can never hang.

Only one IO transfer is in flight at a time. The master sees a stall flag while the registered transfer runs.

Top module: `wb_split_bridge`

## Requirements
- R1: A master address whose bits [31:28] equal 0x0 goes to the block RAM leg, and bits [31:28] equal to 0x4 go to the DRAM leg. Every other address goes to the IO leg. Only the chosen leg's cyc/stb is raised, and m_ack and m_dat_r come from that leg.
- R2: An IO-leg request is captured at a clock edge. The 32-bit IO outputs appear in the following cycle and do not change until the addressed slave acknowledges. m_stall is high from the cycle after capture until the last IO half completes.
- R3: Master byte enables m_sel[3:0] are the lower lane: data bits [31:0], IO address bit 2 = 0, io_sel = m_sel[3:0]. m_sel[7:4] are the upper lane: data bits [63:32], IO address bit 2 = 1, io_sel = m_sel[7:4]. io_adr keeps master address bits [31:3], and its bits [1:0] are zero.
- R4: When both byte-enable nibbles are non-zero, two IO cycles run, lower lane first. m_ack is raised only after the second cycle completes. When exactly one nibble is non-zero, exactly one IO cycle runs, on that lane.
- R5: Read data from a 32-bit slave is returned in the matching lane of m_dat_r. A lane that was not touched reads as zero.
- R6: The IO address 0xC000_k000 + offset, with k below N_IO (address bits [31:24] = 0xC0, bits [23:16] = 0, bits [15:12] = k), drives io_cyc[k] and io_stb[k] only.
- R7: Any IO address with bits [31:24] = 0xC8 drives ext_cyc and ext_stb only.
- R8: An IO-leg address that matches no slot and is not in the external window raises no slave strobe. It returns all-ones in each touched lane. m_ack arrives 2 cycles after the request is presented for a one-lane access and 3 cycles after for a two-lane access.
- R9: m_ack for an IO transfer lasts one cycle and is never high together with m_stall. A new request presented right after the ack is carried out once and correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | 32 | Master byte address |
| m_sel | input | 8 | Master byte enables |
| m_dat_w | input | 64 | Master write data |
| m_dat_r | output | 64 | Master read data |
| m_ack | output | 1 | Master acknowledge |
| m_stall | output | 1 | High while an IO transfer is in progress |
| d64_adr | output | 32 | Address to block RAM and DRAM |
| d64_dat_w | output | 64 | Write data to block RAM and DRAM |
| d64_sel | output | 8 | Byte enables to block RAM and DRAM |
| d64_we | output | 1 | Write enable to block RAM and DRAM |
| bram_cyc | output | 1 | Block RAM cycle |
| bram_stb | output | 1 | Block RAM strobe |
| bram_dat_r | input | 64 | Block RAM read data |
| bram_ack | input | 1 | Block RAM acknowledge |
| dram_cyc | output | 1 | DRAM cycle |
| dram_stb | output | 1 | DRAM strobe |
| dram_dat_r | input | 64 | DRAM read data |
| dram_ack | input | 1 | DRAM acknowledge |
| io_adr | output | 32 | Registered 32-bit IO address |
| io_dat_w | output | 32 | Registered 32-bit IO write data |
| io_sel | output | 4 | IO byte enables |
| io_we | output | 1 | IO write enable |
| io_cyc | output | N_IO | Per-slot IO cycle |
| io_stb | output | N_IO | Per-slot IO strobe |
| io_dat_r | input | 32*N_IO | Per-slot IO read data, slot k in bits [32k+31:32k] |
| io_ack | input | N_IO | Per-slot IO acknowledge |
| ext_cyc | output | 1 | External window cycle |
| ext_stb | output | 1 | External window strobe |
| ext_dat_r | input | 32 | External window read data |
| ext_ack | input | 1 | External window acknowledge |

## Verification
The hardest case to reach is the boundary between two IO halves. The same slave must see its acknowledge drop and then a fresh strobe on the other lane, and the master must stay stalled through the whole sequence. A second hard case is a new master request that arrives in the cycle right after an ack, while the bridge is still leaving its acknowledge state. The bench gets to both by sweeping every leg, slot, external and unmapped address against byte-enable patterns that cover one lane, the other lane and both lanes. It sends each pattern as a read and as a write, and replays the slot accesses back to back with no idle cycle in between. Slave models acknowledge one cycle after each strobe and drop the ack in the following cycle, so every half boundary is exercised.

// File: rtl/wb_split_bridge.sv
module wb_split_bridge #(
  parameter int         N_IO     = 3,
  parameter logic [3:0] BRAM_NIB = 4'h0,
  parameter logic [3:0] DRAM_NIB = 4'h4,
  parameter logic [7:0] IO_BASE  = 8'hC0,
  parameter logic [7:0] EXT_BASE = 8'hC8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               m_cyc,
  input  logic               m_stb,
  input  logic               m_we,
  input  logic [31:0]        m_adr,
  input  logic [7:0]         m_sel,
  input  logic [63:0]        m_dat_w,
  output logic [63:0]        m_dat_r,
  output logic               m_ack,
  output logic               m_stall,
  output logic [31:0]        d64_adr,
  output logic [63:0]        d64_dat_w,
  output logic [7:0]         d64_sel,
  output logic               d64_we,
  output logic               bram_cyc,
  output logic               bram_stb,
  input  logic [63:0]        bram_dat_r,
  input  logic               bram_ack,
  output logic               dram_cyc,
  output logic               dram_stb,
  input  logic [63:0]        dram_dat_r,
  input  logic               dram_ack,
  output logic [31:0]        io_adr,
  output logic [31:0]        io_dat_w,
  output logic [3:0]         io_sel,
  output logic               io_we,
  output logic [N_IO-1:0]    io_cyc,
  output logic [N_IO-1:0]    io_stb,
  input  logic [32*N_IO-1:0] io_dat_r,
  input  logic [N_IO-1:0]    io_ack,
  output logic               ext_cyc,
  output logic               ext_stb,
  input  logic [31:0]        ext_dat_r,
  input  logic               ext_ack
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_ACK} st_t;

  st_t         st;
  logic [31:3] r_adr;
  logic [7:0]  r_sel;
  logic [63:0] r_dat;
  logic        r_we;
  logic [63:0] r_rd;

  logic hit_bram, hit_dram, hit_io;
  logic run, half, ext_hit, unmapped, sl_ack;
  logic [31:0] sl_dat;
  logic [N_IO-1:0] slot_hit;

  // first-level split
  assign hit_bram = m_adr[31:28] == BRAM_NIB;
  assign hit_dram = (m_adr[31:28] == DRAM_NIB) && !hit_bram;
  assign hit_io   = !hit_bram && !hit_dram;

  assign d64_adr   = m_adr;
  assign d64_dat_w = m_dat_w;
  assign d64_sel   = m_sel;
  assign d64_we    = m_we;
  assign bram_cyc  = m_cyc && hit_bram;
  assign bram_stb  = m_cyc && m_stb && hit_bram;
  assign dram_cyc  = m_cyc && hit_dram;
  assign dram_stb  = m_cyc && m_stb && hit_dram;

  // second-level decode on the registered address
  genvar k;
  generate
    for (k = 0; k < N_IO; k++) begin : g_slot
      assign slot_hit[k] = (r_adr[31:24] == IO_BASE) && (r_adr[23:16] == 8'h00) &&
                           (r_adr[15:12] == 4'(k));
    end
  endgenerate

  assign ext_hit  = r_adr[31:24] == EXT_BASE;
  assign unmapped = !ext_hit && !(|slot_hit);
  assign run      = (st == S_LO) || (st == S_HI);
  assign half     = st == S_HI;

  assign io_cyc   = run ? slot_hit : '0;
  assign io_stb   = io_cyc;
  assign ext_cyc  = run && ext_hit;
  assign ext_stb  = ext_cyc;
  assign io_adr   = {r_adr, half, 2'b00};
  assign io_sel   = half ? r_sel[7:4]   : r_sel[3:0];
  assign io_dat_w = half ? r_dat[63:32] : r_dat[31:0];
  assign io_we    = r_we;

  always_comb begin
    sl_ack = ext_hit && ext_ack;
    sl_dat = ext_dat_r;
    for (int i = 0; i < N_IO; i++) begin
      if (slot_hit[i]) begin
        sl_ack = io_ack[i];
        sl_dat = io_dat_r[i*32 +: 32];
      end
    end
    if (unmapped) begin
      sl_ack = 1'b1;
      sl_dat = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      r_adr <= '0;
      r_sel <= '0;
      r_dat <= '0;
      r_we  <= 1'b0;
      r_rd  <= '0;
    end else begin
      case (st)
        S_IDLE: if (m_cyc && m_stb && hit_io) begin
          r_adr <= m_adr[31:3];
          r_sel <= m_sel;
          r_dat <= m_dat_w;
          r_we  <= m_we;
          r_rd  <= '0;
          st    <= (|m_sel[3:0] || !(|m_sel[7:4])) ? S_LO : S_HI;
        end
        S_LO: if (sl_ack) begin
          r_rd[31:0] <= sl_dat;
          st         <= (|r_sel[7:4]) ? S_HI : S_ACK;
        end
        S_HI: if (sl_ack) begin
          r_rd[63:32] <= sl_dat;
          st          <= S_ACK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign m_stall = run;
  assign m_ack   = (m_cyc && hit_bram && bram_ack) || (m_cyc && hit_dram && dram_ack) ||
                   (st == S_ACK);
  assign m_dat_r = hit_bram ? bram_dat_r : hit_dram ? dram_dat_r : r_rd;

  assert_one_leg_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bram_cyc, dram_cyc, ext_cyc, io_cyc}));

  assert_io_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (run && !sl_ack) |=> ($stable(io_adr) && $stable(io_sel) && $stable(io_dat_w) && $stable(io_we)));

  assert_ack_after_run_R4: assert property (@(posedge clk) disable iff (rst)
    (st == S_ACK) |-> $past(run));

  assert_unmapped_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (st == S_LO && unmapped) |=> (st != S_LO));

  assert_no_ack_in_stall_R9: assert property (@(posedge clk) disable iff (rst)
    m_stall |-> !m_ack);

endmodule

// File: tb/wb_split_bridge_tb.sv
module wb_split_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_IO = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic m_cyc = 0, m_stb = 0, m_we = 0;
  logic [31:0] m_adr = '0;
  logic [7:0]  m_sel = '0;
  logic [63:0] m_dat_w = '0;
  logic [63:0] m_dat_r;
  logic m_ack, m_stall;
  logic [31:0] d64_adr;
  logic [63:0] d64_dat_w;
  logic [7:0]  d64_sel;
  logic d64_we, bram_cyc, bram_stb, dram_cyc, dram_stb;
  logic [63:0] bram_dat_r, dram_dat_r;
  logic bram_ack, dram_ack;
  logic [31:0] io_adr, io_dat_w;
  logic [3:0]  io_sel;
  logic io_we;
  logic [N_IO-1:0] io_cyc, io_stb, io_ack;
  logic [32*N_IO-1:0] io_dat_r;
  logic ext_cyc, ext_stb, ext_ack;
  logic [31:0] ext_dat_r;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wb_split_bridge #(.N_IO(N_IO)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] g(int id, logic [31:0] a);
    return {4'hA, 4'(id), a[23:0]};
  endfunction
  function automatic logic [63:0] fb(logic [31:0] a);
    return {a ^ 32'h0BAD_0000, ~a};
  endfunction
  function automatic logic [63:0] fd(logic [31:0] a);
    return {~a, a ^ 32'h0D0D_0000};
  endfunction
  // 8 bram, 9 dram, 7 ext, 0..N_IO-1 slot, -1 unmapped
  function automatic int classify(logic [31:0] a);
    if (a[31:28] == 4'h0) return 8;
    if (a[31:28] == 4'h4) return 9;
    if (a[31:24] == 8'hC8) return 7;
    if (a[31:24] == 8'hC0 && a[23:16] == 8'h00 && int'(a[15:12]) < N_IO) return int'(a[15:12]);
    return -1;
  endfunction

  // slave models: ack one cycle after strobe, then drop
  always_ff @(posedge clk) begin
    if (rst) begin
      bram_ack <= 0; dram_ack <= 0; ext_ack <= 0; io_ack <= '0;
    end else begin
      bram_ack <= bram_cyc && bram_stb && !bram_ack;
      dram_ack <= dram_cyc && dram_stb && !dram_ack;
      ext_ack  <= ext_cyc && ext_stb && !ext_ack;
      for (int k = 0; k < N_IO; k++) io_ack[k] <= io_cyc[k] && io_stb[k] && !io_ack[k];
    end
  end
  assign bram_dat_r = fb(d64_adr);
  assign dram_dat_r = fd(d64_adr);
  assign ext_dat_r  = g(7, io_adr);
  always_comb for (int k = 0; k < N_IO; k++) io_dat_r[k*32 +: 32] = g(k, io_adr);

  // handshake log
  int hs_n;
  int hs_tgt[2];
  logic [31:0] hs_adr[2], hs_dat[2];
  logic [3:0] hs_sel[2];
  logic hs_we[2];
  bit seen_bram, seen_dram, seen_io;

  task automatic log_hs(int t);
    if (hs_n < 2) begin
      hs_tgt[hs_n] = t; hs_adr[hs_n] = io_adr; hs_dat[hs_n] = io_dat_w;
      hs_sel[hs_n] = io_sel; hs_we[hs_n] = io_we;
    end
    hs_n++;
  endtask

  always @(posedge clk) if (!rst) begin
    if (bram_cyc) seen_bram = 1;
    if (dram_cyc) seen_dram = 1;
    if (|io_cyc || ext_cyc) seen_io = 1;
    for (int k = 0; k < N_IO; k++) if (io_cyc[k] && io_ack[k]) log_hs(k);
    if (ext_cyc && ext_ack) log_hs(7);
  end

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic txn(logic [31:0] a, logic [7:0] sel, logic we, bit b2b);
    logic [63:0] wd, rd, exp;
    int c, t, nh;
    bit got, st1, st_ack, lo, hi;
    wd = {~a, a ^ {24'h0, sel}};
    if (!b2b) @(negedge clk);
    hs_n = 0; seen_bram = 0; seen_dram = 0; seen_io = 0;
    m_cyc = 1; m_stb = 1; m_adr = a; m_sel = sel; m_we = we; m_dat_w = wd;
    c = 0; got = 0; st1 = 0; st_ack = 0; rd = '0;
    while (!got && c < 20) begin
      @(negedge clk);
      c++;
      if (c == 1) st1 = m_stall;
      if (m_ack) begin got = 1; rd = m_dat_r; st_ack = m_stall; end
    end
    m_cyc = 0; m_stb = 0;
    t = classify(a);
    lo = |sel[3:0]; hi = |sel[7:4]; nh = int'(lo) + int'(hi);
    chk(got, "R9 ack arrives", 64'(got), 64'd1);
    if (t == 8) begin
      chk(seen_bram && !seen_dram && !seen_io, "R1 bram leg only", {seen_bram, seen_dram, seen_io}, 3'b100);
      if (!we) chk(rd == fb(a), "R1 bram read data", rd, fb(a));
    end else if (t == 9) begin
      chk(seen_dram && !seen_bram && !seen_io, "R1 dram leg only", {seen_bram, seen_dram, seen_io}, 3'b010);
      if (!we) chk(rd == fd(a), "R1 dram read data", rd, fd(a));
    end else begin
      chk(!seen_bram && !seen_dram, "R1 io leg only", {seen_bram, seen_dram}, 0);
      if (!b2b) chk(st1, "R2 stall after capture", 64'(st1), 1);
      chk(!st_ack, "R9 no stall with ack", 64'(st_ack), 0);
      exp = '0;
      for (int h = 0; h < 2; h++) begin
        if ((h == 0 && lo) || (h == 1 && hi))
          exp[h*32 +: 32] = (t < 0) ? 32'hFFFF_FFFF : g(t, {a[31:3], h[0], 2'b00});
      end
      if (t < 0) begin
        chk(hs_n == 0 && !seen_io, "R8 no slave strobe", 64'(hs_n), 0);
        if (!b2b) chk(c == 1 + nh, "R8 ack latency", 64'(c), 64'(1 + nh));
        if (!we) chk(rd == exp, "R8 all-ones data", rd, exp);
      end else begin
        chk(hs_n == nh, "R4 number of IO cycles", 64'(hs_n), 64'(nh));
        for (int i = 0; i < nh && i < 2; i++) begin
          int h;
          h = (i == 0 && lo) ? 0 : 1;
          chk(hs_tgt[i] == t, (t == 7) ? "R7 external window routed" : "R6 slot routed",
              64'(hs_tgt[i]), 64'(t));
          chk(hs_adr[i] == {a[31:3], h[0], 2'b00}, "R4 R3 lane order and address",
              hs_adr[i], {a[31:3], h[0], 2'b00});
          chk(hs_sel[i] == sel[h*4 +: 4], "R3 lane byte enables", hs_sel[i], sel[h*4 +: 4]);
          chk(hs_we[i] == we, "R3 write enable", hs_we[i], we);
          if (we) chk(hs_dat[i] == wd[h*32 +: 32], "R3 lane write data", hs_dat[i], wd[h*32 +: 32]);
        end
        if (!we) chk(rd == exp, "R5 read lane placement", rd, exp);
      end
    end
  endtask

  initial begin
    logic [31:0] addrs[9];
    logic [7:0] sels[6];
    addrs = '{32'h0000_1238, 32'h4000_0050, 32'hC000_0010, 32'hC000_1020, 32'hC000_2008,
              32'hC812_3400, 32'hC000_5000, 32'hC010_0000, 32'h8000_0000};
    sels  = '{8'h0F, 8'hF0, 8'hFF, 8'h81, 8'h3C, 8'h10};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!m_ack && !m_stall, "R9 reset idle", {m_ack, m_stall}, 0);
    chk(!bram_cyc && !dram_cyc && io_cyc == 0 && !ext_cyc, "R1 reset no leg",
        {bram_cyc, dram_cyc, io_cyc, ext_cyc}, 0);
    foreach (addrs[i]) foreach (sels[j]) for (int w = 0; w < 2; w++)
      txn(addrs[i], sels[j], w[0], 0);
    // back-to-back IO requests
    for (int i = 2; i < 6; i++) foreach (sels[j]) txn(addrs[i], sels[j], 1'b0, 1);
    for (int i = 2; i < 6; i++) txn(addrs[i], 8'hFF, 1'b1, 1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule